// File: doc/BRIEF.md
# Programmable Tap Delay Line

A clocked delay line that holds a single-bit input back by a number of clock periods. The number is picked at run time by a 5-bit select code. The delay in cycles equals a fixed inherent part plus a per-step increment times the select code. Both parts are parameters. The input enters a shift register on every clock. The output is a registered read of the stage that the current select code addresses. The select is not held in a register, so a new code takes effect on the next clock edge. A blanking input forces the output low. The shift register keeps moving while the output is blanked.

A small guard watches how the select is used. It raises a sticky violation flag when the select moves to a larger code too soon after the last change on the output, because that would replay stale samples. A flush state machine reports through `ready` when the line has cleared after blanking. The line counts as clear once blank has stayed high and the input has stayed low for select·step cycles.

Guard states: `GD_WATCH` moves to `GD_TRIPPED` on an unsafe select increase. `GD_TRIPPED` stays until reset. Flush states: `FL_CLEAR` moves to `FL_RUN` when blank is low, and to `FL_FLUSH` when the input is high while blanked. `FL_RUN` moves to `FL_FLUSH` when blank rises. In `FL_FLUSH`:
- a high input restarts the count and the machine stays in `FL_FLUSH`;
- blank falling moves it to `FL_RUN`;
- a completed count moves it to `FL_CLEAR`.

Reset enters `FL_CLEAR` and `GD_WATCH`.

Top module: `prog_tap_delay`

## Requirements
- R1: With default parameters (inherent 2, step 1), an input value sampled at clock edge t appears on `dout` just after edge t + 2 + sel, while `blank` is low.
- R2: All 32 select codes are usable. The latency of an isolated input pulse is exactly 2 + sel cycles, so latency rises by one step per code.
- R3: A `blank` sampled high at an edge drives `dout` low after that edge. The shift register keeps shifting while blanked, so data entered during blanking still appears later.
- R4: The select is not latched. The tap read at each edge is the one addressed by `sel` at that edge, even when `sel` changes every cycle.
- R5: Synchronous reset clears every stage, drives `dout` low, sets `ready` high and clears `viol`.
- R6: A change of `sel` to a larger code sets `viol` when fewer than (new−old)·step cycles have passed since the last change of `dout`.
- R7: A decrease of `sel`, or an increase made after enough quiet cycles on `dout`, leaves `viol` low.
- R8: `viol` stays high until reset.
- R9: When `blank` is first sampled high while the line is running, `ready` rises just after the (N+1)th edge, counted from that edge itself, where N = max(sel·step, 1).
- R10: An input sampled high while `blank` is high drops `ready` after that edge. The flush count restarts, and `ready` rises N edges later.
- R11: `blank` sampled low makes `ready` low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Data to be delayed |
| sel | input | 5 | Delay step code, 0 to 31 |
| blank | input | 1 | High forces `dout` low and starts a flush |
| dout | output | 1 | Delayed data |
| ready | output | 1 | Line is clear after blanking |
| viol | output | 1 | Sticky unsafe-select-change flag |

## Verification
The bench goes after an off-by-one tap index, which would shift every latency by one cycle in the 32-code sweep. It also goes after a select held in a register, which would lag the per-cycle select changes by one edge. A reset that leaves the stages intact would let ones loaded before reset leak out afterwards. A flush counter that does not restart on a high input, or that counts one cycle too many, would raise `ready` at the wrong edge. The guard is driven with an increase right after output activity, and with a decrease and a quiet increase, so a missing or over-eager flag shows up.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

    typedef enum logic [1:0] {
        FL_RUN   = 2'd0,
        FL_FLUSH = 2'd1,
        FL_CLEAR = 2'd2
    } flush_state_t;

    typedef enum logic {
        GD_WATCH   = 1'b0,
        GD_TRIPPED = 1'b1
    } guard_state_t;

endpackage

// File: rtl/tdl_shift.sv
module tdl_shift #(
    parameter int DEPTH = 33
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] stage
);

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stage[k] <= 1'b0;
                else     stage[k] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stage[k] <= 1'b0;
                else     stage[k] <= stage[k-1];
            end
        end
    end

endmodule

// File: rtl/tdl_tap_read.sv
module tdl_tap_read #(
    parameter int DEPTH    = 33,
    parameter int SEL_W    = 5,
    parameter int INHERENT = 2,
    parameter int STEP     = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] stage,
    input  logic [SEL_W-1:0] sel,
    input  logic             blank,
    output logic             dout
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IW-1:0] idx;
    logic          tap_bit;

    // Stage k holds the input sampled k+1 edges ago; the output register adds one more.
    always_comb begin
        idx     = IW'(INHERENT - 1 + int'(sel) * STEP);
        tap_bit = stage[idx];
    end

    always_ff @(posedge clk) begin
        if (rst)        dout <= 1'b0;
        else if (blank) dout <= 1'b0;
        else            dout <= tap_bit;
    end

    assert_blank_forces_low_R3: assert property (
        @(posedge clk) disable iff (rst) blank |=> !dout
    );

endmodule

// File: rtl/tdl_sel_guard.sv
module tdl_sel_guard
    import tdl_pkg::*;
#(
    parameter int SEL_W = 5,
    parameter int STEP  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             dout,
    output logic             viol
);

    localparam int NSEL   = 1 << SEL_W;
    localparam int MAXGAP = (NSEL - 1) * STEP;
    localparam int GAP_W  = $clog2(MAXGAP + 1);
    localparam int CW     = GAP_W + 1;

    guard_state_t     state, state_nx;
    logic [SEL_W-1:0] prev_sel;
    logic             dout_d;
    logic [CW-1:0]    since;
    logic [CW-1:0]    gap;
    logic             unsafe;

    // Quiet-time counter since the last output change, saturating at the largest gap.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sel <= sel;
            dout_d   <= 1'b0;
            since    <= CW'(MAXGAP);
        end else begin
            prev_sel <= sel;
            dout_d   <= dout;
            if (dout != dout_d)          since <= '0;
            else if (since < CW'(MAXGAP)) since <= since + 1'b1;
        end
    end

    always_comb begin
        gap    = CW'((int'(sel) - int'(prev_sel)) * STEP);
        unsafe = (sel != prev_sel) && (sel > prev_sel) && (since < gap);
    end

    always_ff @(posedge clk) begin
        if (rst) state <= GD_WATCH;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            GD_WATCH:   if (unsafe) state_nx = GD_TRIPPED;
            GD_TRIPPED: state_nx = GD_TRIPPED;
            default:    state_nx = GD_WATCH;
        endcase
    end

    always_comb viol = (state == GD_TRIPPED);

    assert_viol_sticky_R8: assert property (
        @(posedge clk) disable iff (rst) viol |=> viol
    );

endmodule

// File: rtl/tdl_flush_fsm.sv
module tdl_flush_fsm
    import tdl_pkg::*;
#(
    parameter int SEL_W = 5,
    parameter int STEP  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             blank,
    input  logic             din,
    output logic             ready
);

    localparam int NSEL   = 1 << SEL_W;
    localparam int MAXGAP = (NSEL - 1) * STEP;
    localparam int CW     = $clog2(MAXGAP + 1) + 1;

    flush_state_t  state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic [CW-1:0] need;
    logic [CW-1:0] target;

    always_comb begin
        need   = CW'(int'(sel) * STEP);
        target = (need == '0) ? CW'(1) : need;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FL_CLEAR;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            FL_RUN: begin
                if (blank) begin
                    state_nx = FL_FLUSH;
                    cnt_nx   = '0;
                end
            end
            FL_FLUSH: begin
                if (!blank) begin
                    state_nx = FL_RUN;
                end else if (din) begin
                    cnt_nx = '0;
                end else if (CW'(cnt + 1'b1) >= target) begin
                    state_nx = FL_CLEAR;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            FL_CLEAR: begin
                if (!blank) begin
                    state_nx = FL_RUN;
                end else if (din) begin
                    state_nx = FL_FLUSH;
                    cnt_nx   = '0;
                end
            end
            default: state_nx = FL_CLEAR;
        endcase
    end

    always_comb ready = (state == FL_CLEAR);

    assert_input_restarts_flush_R10: assert property (
        @(posedge clk) disable iff (rst) (blank && din) |=> !ready
    );

    assert_running_not_ready_R11: assert property (
        @(posedge clk) disable iff (rst) !blank |=> !ready
    );

    assert_ready_needs_blank_R9: assert property (
        @(posedge clk) disable iff (rst) $rose(ready) |-> $past(blank)
    );

endmodule

// File: rtl/prog_tap_delay.sv
module prog_tap_delay #(
    parameter int SEL_W    = 5,
    parameter int INHERENT = 2,
    parameter int STEP     = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    input  logic             blank,
    output logic             dout,
    output logic             ready,
    output logic             viol
);

    localparam int NSEL  = 1 << SEL_W;
    localparam int DEPTH = INHERENT + (NSEL - 1) * STEP;

    logic [DEPTH-1:0] stage;

    tdl_shift #(.DEPTH(DEPTH)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .din   (din),
        .stage (stage)
    );

    tdl_tap_read #(
        .DEPTH    (DEPTH),
        .SEL_W    (SEL_W),
        .INHERENT (INHERENT),
        .STEP     (STEP)
    ) u_tap (
        .clk   (clk),
        .rst   (rst),
        .stage (stage),
        .sel   (sel),
        .blank (blank),
        .dout  (dout)
    );

    tdl_sel_guard #(.SEL_W(SEL_W), .STEP(STEP)) u_guard (
        .clk  (clk),
        .rst  (rst),
        .sel  (sel),
        .dout (dout),
        .viol (viol)
    );

    tdl_flush_fsm #(.SEL_W(SEL_W), .STEP(STEP)) u_flush (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .blank (blank),
        .din   (din),
        .ready (ready)
    );

endmodule

// File: tb/prog_tap_delay_bench.sv
`timescale 1ns/1ps
module prog_tap_delay_bench;

    localparam int SEL_W    = 5;
    localparam int INHERENT = 2;
    localparam int STEP     = 1;
    localparam int NVEC     = 8;

    // {sel[4:0], input pattern[15:0]}
    localparam logic [20:0] VEC [NVEC] = '{
        {5'd0,  16'hA5C3}, {5'd1,  16'hF00F}, {5'd7,  16'h1234},
        {5'd13, 16'h8001}, {5'd31, 16'hCAFE}, {5'd20, 16'h0FF0},
        {5'd2,  16'h5555}, {5'd31, 16'h3C3C}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             din = 1'b0;
    logic [SEL_W-1:0] sel = '0;
    logic             blank = 1'b0;
    logic             dout, ready, viol;

    int          checks = 0;
    int          fails  = 0;
    logic [63:0] hist   = '0;

    always #2.5 clk = ~clk;

    prog_tap_delay #(.SEL_W(SEL_W), .INHERENT(INHERENT), .STEP(STEP)) u_prog_tap_delay (
        .clk(clk), .rst(rst), .din(din), .sel(sel), .blank(blank),
        .dout(dout), .ready(ready), .viol(viol)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive din, sample after the edge, compare with the history model.
    task automatic step(input logic d, input string req);
        int exp;
        din = d;
        @(posedge clk);
        #1;
        hist = {hist[62:0], d};
        exp  = blank ? 0 : int'(hist[INHERENT + STEP * int'(sel)]);
        chk(req, int'(dout), exp);
    endtask

    task automatic do_reset();
        rst = 1'b1; din = 1'b0; blank = 1'b0; sel = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R5 dout", int'(dout), 0);
        chk("R5 ready", int'(ready), 1);
        chk("R5 viol", int'(viol), 0);
        rst  = 1'b0;
        hist = '0;
    endtask

    task automatic wait_ready(input string req, input int exp);
        int n = 0;
        do begin
            step(1'b0, req);
            n++;
        end while (!ready && n < 100);
        chk(req, n, exp);
    endtask

    initial begin
        #900000;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        int n;
        do_reset();

        // Vector table walk: R1 per entry, tail of zeros flushes the pattern out.
        for (int v = 0; v < NVEC; v++) begin
            sel = VEC[v][20:16];
            for (int b = 15; b >= 0; b--) step(VEC[v][b], "R1");
            repeat (36) step(1'b0, "R1 tail");
        end

        // R2: isolated pulse latency for every code.
        for (int s = 0; s < 32; s++) begin
            sel = SEL_W'(s);
            repeat (40) step(1'b0, "R2");
            step(1'b1, "R2");
            n = 0;
            do begin
                step(1'b0, "R2");
                n++;
            end while (!dout && n < 80);
            chk("R2 latency", n, INHERENT + STEP * s);
        end

        // R4: select changes every cycle, tap follows at once.
        lfsr = 8'h5B;
        for (int i = 0; i < 60; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            sel  = lfsr[4:0];
            step(lfsr[7], "R4");
        end

        // R3: blanked output, line keeps shifting.
        sel = 5'd6;
        blank = 1'b1;
        for (int i = 0; i < 20; i++) step(1'(i % 3 == 0), "R3 blanked");
        blank = 1'b0;
        repeat (40) step(1'b0, "R3 after");

        // R5: stages cleared by reset.
        sel = 5'd31;
        repeat (10) step(1'b1, "R5 load");
        do_reset();
        sel = 5'd31;
        repeat (40) step(1'b0, "R5 cleared");

        // R6 then R8.
        do_reset();
        for (int i = 0; i < 12; i++) step(1'(i % 2), "R6 toggle");
        sel = 5'd31;
        repeat (3) step(1'b0, "R6");
        chk("R6 viol", int'(viol), 1);
        repeat (50) step(1'b0, "R8");
        chk("R8 sticky", int'(viol), 1);
        do_reset();

        // R7: quiet increase and a decrease soon after output activity.
        repeat (40) step(1'b0, "R7");
        sel = 5'd31;
        repeat (5) step(1'b0, "R7");
        chk("R7 quiet increase", int'(viol), 0);
        step(1'b1, "R7");
        repeat (35) step(1'b0, "R7");
        sel = 5'd4;
        repeat (3) step(1'b0, "R7");
        chk("R7 decrease", int'(viol), 0);

        // R9, R10, R11: flush readiness.
        do_reset();
        sel = 5'd5;
        step(1'b0, "R11");
        chk("R11 running", int'(ready), 0);
        blank = 1'b1;
        wait_ready("R9 sel5", 6);
        step(1'b1, "R10");
        chk("R10 drop", int'(ready), 0);
        wait_ready("R10 restart", 5);
        blank = 1'b0;
        step(1'b0, "R11");
        chk("R11 unblank", int'(ready), 0);
        blank = 1'b1;
        repeat (3) step(1'b0, "R10");
        step(1'b1, "R10");
        wait_ready("R10 midflush", 5);
        blank = 1'b0;
        sel = 5'd0;
        step(1'b0, "R9");
        blank = 1'b1;
        wait_ready("R9 sel0", 2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule